// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block turns a peripheral clock into the timing pulses that a serial transmitter and receiver use. It produces a single-cycle oversample pulse at sixteen times the baud rate, and a bit pulse on every sixteenth oversample pulse. The divisor has two parts: an integer part of 16 bits and a fraction of 6 bits in units of 1/64. The average oversample period is therefore integer + fraction/64 clock cycles. A modulo-64 phase accumulator adds the fraction once per oversample period. On every carry out of that accumulator, the period is stretched by one clock.

Software works out the two divisor parts from the wanted baud rate. It writes them to the divisor inputs while the block is disabled, and then sets the enable. Each clock edge with the enable low copies the divisor inputs into an internal shadow copy. While the block is enabled, the shadow copy is frozen. Dropping the enable clears the period counter, the phase accumulator and the bit counter, so each enable starts from a known phase. An integer part of zero is invalid and produces no pulses.

Top module: `frac_baud_gen`

## Requirements
- R1: After reset the shadow divisor is zero, so both outputs stay low even with the enable high, until a divisor has been captured with the enable low.
- R2: The divisor inputs are captured only on clock edges with the enable low; changes to them while enabled have no effect on the pulse timing.
- R3: With fraction zero and integer N ≥ 1, the oversample pulse is high for one cycle in every N. The first pulse falls in the N-th cycle with the enable high, counting the first enabled cycle as cycle 1.
- R4: With fraction F, oversample period k after enable (k = 1, 2, …) lasts N + floor(k·F/64) − floor((k−1)·F/64) cycles. Periods are therefore N or N+1 cycles long, and 64 consecutive periods take 64·N + F cycles.
- R5: The bit pulse is high exactly in the cycle of every 16th oversample pulse after enable (the 16th, 32nd, …), and never without one.
- R6: While the shadow integer part is zero, neither output pulses, whatever the fraction.
- R7: With the enable low, both outputs are low. Re-enabling restarts the period count, the phase accumulator and the bit count from zero.
- R8: With integer 1 and fraction zero, the oversample pulse is high in every enabled cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; when low, divisor captured and counters cleared |
| int_div_i | input | 16 | Integer part of the oversample divisor |
| frac_div_i | input | 6 | Fractional part of the divisor, in 1/64 clock |
| osr_tick_o | output | 1 | Single-cycle pulse at 16x the baud rate |
| bit_tick_o | output | 1 | Single-cycle pulse once per bit time |

## Verification
Two events can land on the same cycle: a carry from the phase accumulator that stretches a period, and the 16th oversample pulse that raises the bit pulse. Fractions such as 32, 63 and 48 make the carry fall on or next to the period that ends in a bit pulse. Each period length is checked against the floor formula, and the bit pulse is checked to appear only on pulse counts divisible by 16. A second case is disabling after a run has left the accumulator non-zero, then re-enabling. The first periods after the restart must match a fresh sequence.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
   localparam int unsigned FBG_INT_W  = 16;
   localparam int unsigned FBG_FRAC_W = 6;
   localparam int unsigned FBG_OVS    = 16;

   typedef enum logic [0:0] {
      FBG_HALTED  = 1'b0,
      FBG_RUNNING = 1'b1
   } fbg_run_e;
endpackage

// File: rtl/fbg_divisor_latch.sv
module fbg_divisor_latch #(
   parameter int unsigned INT_W  = 16,
   parameter int unsigned FRAC_W = 6
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              en_i,
   input  logic [INT_W-1:0]  int_div_i,
   input  logic [FRAC_W-1:0] frac_div_i,
   output logic [INT_W-1:0]  int_q_o,
   output logic [FRAC_W-1:0] frac_q_o,
   output logic              valid_o
);
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         int_q_o  <= '0;
         frac_q_o <= '0;
      end else if (!en_i) begin
         int_q_o  <= int_div_i;
         frac_q_o <= frac_div_i;
      end
   end

   assign valid_o = |int_q_o;
endmodule

// File: rtl/fbg_frac_divider.sv
module fbg_frac_divider #(
   parameter int unsigned INT_W  = 16,
   parameter int unsigned FRAC_W = 6
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              run_i,
   input  logic [INT_W-1:0]  int_i,
   input  logic [FRAC_W-1:0] frac_i,
   output logic              tick_o,
   output logic [FRAC_W-1:0] acc_o
);
   localparam int unsigned CNT_W = INT_W + 1;

   logic [CNT_W-1:0]  cnt_q;
   logic [FRAC_W-1:0] acc_q;
   logic [FRAC_W:0]   phase_sum;
   logic              stretch;
   logic [CNT_W-1:0]  period_len;
   logic              period_end;

   assign phase_sum  = {1'b0, acc_q} + {1'b0, frac_i};
   assign stretch    = phase_sum[FRAC_W];
   assign period_len = {1'b0, int_i} + CNT_W'(stretch);
   assign period_end = (cnt_q == period_len - CNT_W'(1));
   assign tick_o     = run_i && period_end;
   assign acc_o      = acc_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
         acc_q <= '0;
      end else if (!run_i) begin
         cnt_q <= '0;
         acc_q <= '0;
      end else if (period_end) begin
         cnt_q <= '0;
         acc_q <= phase_sum[FRAC_W-1:0];
      end else begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end
endmodule

// File: rtl/fbg_bit_counter.sv
module fbg_bit_counter #(
   parameter int unsigned OVS = 16
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic run_i,
   input  logic osr_tick_i,
   output logic bit_tick_o
);
   generate
      if (OVS == 1) begin : g_direct
         assign bit_tick_o = osr_tick_i;
      end else begin : g_count
         localparam int unsigned SUB_W = $clog2(OVS);
         logic [SUB_W-1:0] sub_q;
         logic             sub_last;

         assign sub_last   = (sub_q == SUB_W'(OVS - 1));
         assign bit_tick_o = osr_tick_i && sub_last;

         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               sub_q <= '0;
            end else if (!run_i) begin
               sub_q <= '0;
            end else if (osr_tick_i) begin
               sub_q <= sub_last ? '0 : sub_q + SUB_W'(1);
            end
         end
      end
   endgenerate
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
   import fbg_pkg::*;
#(
   parameter int unsigned INT_W  = FBG_INT_W,
   parameter int unsigned FRAC_W = FBG_FRAC_W,
   parameter int unsigned OVS    = FBG_OVS
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              en_i,
   input  logic [INT_W-1:0]  int_div_i,
   input  logic [FRAC_W-1:0] frac_div_i,
   output logic              osr_tick_o,
   output logic              bit_tick_o
);
   generate
      if (INT_W < 2) begin : g_bad_int
         $error("frac_baud_gen: INT_W must be at least 2");
      end
      if (FRAC_W < 1) begin : g_bad_frac
         $error("frac_baud_gen: FRAC_W must be at least 1");
      end
      if (OVS < 1) begin : g_bad_ovs
         $error("frac_baud_gen: OVS must be at least 1");
      end
   endgenerate

   logic [INT_W-1:0]  div_int_q;
   logic [FRAC_W-1:0] div_frac_q;
   logic              div_valid;
   logic [FRAC_W-1:0] frac_acc;
   fbg_run_e          run_state;

   assign run_state = (en_i && div_valid) ? FBG_RUNNING : FBG_HALTED;

   fbg_divisor_latch #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_latch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .en_i       (en_i),
      .int_div_i  (int_div_i),
      .frac_div_i (frac_div_i),
      .int_q_o    (div_int_q),
      .frac_q_o   (div_frac_q),
      .valid_o    (div_valid)
   );

   fbg_frac_divider #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_div (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .run_i  (run_state == FBG_RUNNING),
      .int_i  (div_int_q),
      .frac_i (div_frac_q),
      .tick_o (osr_tick_o),
      .acc_o  (frac_acc)
   );

   fbg_bit_counter #(.OVS(OVS)) u_bits (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .run_i      (run_state == FBG_RUNNING),
      .osr_tick_i (osr_tick_o),
      .bit_tick_o (bit_tick_o)
   );
endmodule

// File: rtl/fbg_checker.sv
module fbg_checker #(
   parameter int unsigned INT_W  = 16,
   parameter int unsigned FRAC_W = 6
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              en_i,
   input logic              osr_tick_o,
   input logic              bit_tick_o,
   input logic [INT_W-1:0]  int_q,
   input logic [FRAC_W-1:0] frac_q,
   input logic [FRAC_W-1:0] acc
);
   assert_bit_needs_osr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bit_tick_o |-> osr_tick_o);

   assert_quiet_when_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |-> (!osr_tick_o && !bit_tick_o));

   assert_zero_div_silent_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (int_q == '0) |-> !osr_tick_o);

   assert_divisor_frozen_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && $past(en_i)) |-> ($stable(int_q) && $stable(frac_q)));

   assert_tick_spacing_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (osr_tick_o && (int_q > INT_W'(1))) |=> !osr_tick_o);

   assert_phase_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && !osr_tick_o) |=> $stable(acc));

   assert_unit_div_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && (int_q == INT_W'(1)) && (frac_q == '0)) |-> osr_tick_o);
endmodule

bind frac_baud_gen fbg_checker #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_fbg_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .en_i       (en_i),
   .osr_tick_o (osr_tick_o),
   .bit_tick_o (bit_tick_o),
   .int_q      (div_int_q),
   .frac_q     (div_frac_q),
   .acc        (frac_acc)
);

// File: tb/frac_baud_gen_bench.sv
`timescale 1ns/1ps
module frac_baud_gen_bench;
   localparam int INT_W  = 16;
   localparam int FRAC_W = 6;
   localparam int NVEC   = 8;

   // each entry: {integer part, fraction}
   localparam logic [21:0] VEC_TAB [NVEC] = '{
      {16'd5,  6'd0},
      {16'd3,  6'd32},
      {16'd4,  6'd1},
      {16'd1,  6'd0},
      {16'd1,  6'd63},
      {16'd2,  6'd21},
      {16'd7,  6'd63},
      {16'd10, 6'd48}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              en = 1'b0;
   logic [INT_W-1:0]  int_div = '0;
   logic [FRAC_W-1:0] frac_div = '0;
   logic              osr_tick;
   logic              bit_tick;

   int vec_count  = 0;
   int fail_count = 0;
   bit done       = 1'b0;

   always #4 clk = ~clk;

   frac_baud_gen u_frac_baud_gen (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .en_i       (en),
      .int_div_i  (int_div),
      .frac_div_i (frac_div),
      .osr_tick_o (osr_tick),
      .bit_tick_o (bit_tick)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      vec_count++;
      if (!ok) begin
         fail_count++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic load_div(input int n, input int f);
      @(negedge clk);
      en       = 1'b0;
      int_div  = INT_W'(n);
      frac_div = FRAC_W'(f);
      @(negedge clk);
      @(negedge clk);
   endtask

   // enables at the current negedge and checks the given number of periods
   task automatic run_periods(input int n, input int f, input int periods, input string req);
      int len = 0;
      int k   = 0;
      en = 1'b1;
      forever begin
         #1;
         len++;
         if (osr_tick) begin
            int exp_len;
            k++;
            exp_len = n + ((k * f) >> 6) - (((k - 1) * f) >> 6);
            check(len == exp_len, req, len, exp_len);
            check(bit_tick == ((k % 16) == 0), "R5", int'(bit_tick), int'((k % 16) == 0));
            len = 0;
         end else if (bit_tick) begin
            check(1'b0, "R5", 1, 0);
         end
         if (k >= periods) break;
         if (len > n + 2) begin
            check(1'b0, req, len, n + 1);
            break;
         end
         @(negedge clk);
      end
   endtask

   task automatic expect_silent(input int cycles, input string req);
      int seen = 0;
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         #1;
         if (osr_tick || bit_tick) seen++;
      end
      check(seen == 0, req, seen, 0);
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         fail_count++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("== %0d vectors applied, %0d miscompares ==", vec_count, fail_count);
         $finish;
      end
   end

   initial begin
      // R1: reset with enable high; shadow stays zero
      en = 1'b1;
      int_div = 16'd7;
      frac_div = 6'd3;
      #1;
      check(!osr_tick && !bit_tick, "R1", int'(osr_tick), 0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      expect_silent(50, "R1");

      // table: R3, R4, R5, R8
      for (int v = 0; v < NVEC; v++) begin
         int n = int'(VEC_TAB[v][21:6]);
         int f = int'(VEC_TAB[v][5:0]);
         load_div(n, f);
         run_periods(n, f, 64, (f == 0) ? ((n == 1) ? "R8" : "R3") : "R4");
      end

      // R2: inputs changed while enabled are ignored
      load_div(3, 0);
      en = 1'b1;
      int_div = 16'd9;
      frac_div = 6'd50;
      run_periods(3, 0, 20, "R2");

      // R6: zero integer part never ticks
      load_div(0, 10);
      en = 1'b1;
      expect_silent(200, "R6");

      // R7: disable clears phase; restart matches a fresh sequence
      load_div(6, 40);
      run_periods(6, 40, 5, "R4");
      @(negedge clk);
      en = 1'b0;
      expect_silent(10, "R7");
      @(negedge clk);
      run_periods(6, 40, 20, "R7");
      @(negedge clk);
      en = 1'b0;
      #1;
      check(!osr_tick && !bit_tick, "R7", int'(osr_tick), 0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vec_count, fail_count);
      $finish;
   end
endmodule